// File: doc/BRIEF.md
# Phase Frequency Detector with Antibacklash Delay

This block is the digital phase frequency detector of a PLL frequency synthesizer. One input is the output of the reference divider. The other is the output of the feedback divider, whose ratio is N = B·P + A. A rising edge on the reference input raises the `up_o` output, and a rising edge on the feedback input raises `dn_o`. The output belonging to the earlier edge therefore stays high for longer, by the lead in cycles. Both outputs are registered. All timing is counted in cycles of a fast sampling clock that samples the two divider outputs as levels.

Once both outputs are high, a clear of both detector flops is held off for a programmable number of cycles, chosen by a 2-bit select input. This keeps a minimum-width coincident pulse on both outputs even when the two inputs are exactly in phase, so the transfer function has no dead zone. A rising edge that arrives while both outputs are high is not lost. It is held pending, and after the clear its output drops for one cycle and then rises again.

Top module: `phase_freq_det`

## Requirements
- R1: While `rst` is high at a clock edge, both `up_o` and `dn_o` are low after that edge.
- R2: A rising edge (sampled 0 then 1) on `ref_div_i` sets `up_o` at the clock edge that samples the 1, and one on `fb_div_i` sets `dn_o` the same way. An input held high causes no further edge.
- R3: Once both outputs are high they stay high together and fall at the same clock edge. Neither falls alone.
- R4: Both outputs stay high together for D cycles, where D is selected by `abl_sel_i`: code 2'b00 gives 3, 2'b01 gives 1, 2'b10 gives 6 and 2'b11 gives 3 (all parameters).
- R5: Edges arriving on both inputs in the same cycle give pulses of exactly D cycles on both outputs.
- R6: When one input's edge leads the other by L cycles, the leading output is high for L + D cycles and the lagging output for D cycles.
- R7: A rising edge on an input while both outputs are high is held pending. That output is low for the one cycle after the clear and high from the next cycle on.
- R8: A rising edge on an input whose output is already high while the other output is low has no effect: the pulse is not lengthened and nothing is left pending after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_div_i | input | 1 | Reference divider output, sampled as a level |
| fb_div_i | input | 1 | Feedback divider output, sampled as a level |
| abl_sel_i | input | 2 | Antibacklash delay select |
| up_o | output | 1 | Pump-up pulse, registered |
| dn_o | output | 1 | Pump-down pulse, registered |

## Verification
The main function is driven with edge pairs under every delay code. Some pairs are coincident, which shows the minimum pulse and the absence of a dead zone. Others have the reference leading or the feedback leading by several cycles, which separates the lead-dependent width from the fixed overlap and shows that the detector is symmetric. In each pair the falling cycles of the two outputs are compared to confirm that they clear together. Directed cases cover three situations that a plain reset-on-coincidence detector would get wrong: a repeat edge on an input whose output is already high, an edge that lands inside the clear window, and a reset in mid-pulse.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_FB  = 1;

  function automatic int unsigned abl_cycles(input logic [1:0] code,
                                             input int unsigned d0, input int unsigned d1,
                                             input int unsigned d2, input int unsigned d3);
    case (code)
      2'b00:   return d0;
      2'b01:   return d1;
      2'b10:   return d2;
      default: return d3;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  // An input already high when reset lifts is not an edge.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/pfd_clear_timer.sv
module pfd_clear_timer #(
  parameter int unsigned D00 = 3,
  parameter int unsigned D01 = 1,
  parameter int unsigned D10 = 6,
  parameter int unsigned D11 = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       win_i,
  input  logic [1:0] sel_i,
  output logic       clear_o
);
  import pfd_pkg::*;

  localparam int unsigned DMAX  = max4(D00, D01, D10, D11);
  localparam int unsigned CNT_W = (DMAX < 2) ? 1 : $clog2(DMAX + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   dly_w;
  logic [CNT_W:0]   held_w;

  assign dly_w   = (CNT_W+1)'(abl_cycles(sel_i, D00, D01, D10, D11));
  assign held_w  = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign clear_o = win_i && (held_w >= dly_w);

  always_ff @(posedge clk) begin
    if (rst || !win_i || clear_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/pfd_chan.sv
module pfd_chan (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic win_i,
  input  logic clear_i,
  output logic out_q
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (clear_i) begin
      out_q <= 1'b0;
      if (rise_i) pend_q <= 1'b1;
    end else if (win_i) begin
      if (rise_i) pend_q <= 1'b1;
    end else if (pend_q || rise_i) begin
      out_q  <= 1'b1;
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/phase_freq_det.sv
module phase_freq_det #(
  parameter int unsigned DLY_00 = 3,
  parameter int unsigned DLY_01 = 1,
  parameter int unsigned DLY_10 = 6,
  parameter int unsigned DLY_11 = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_div_i,
  input  logic       fb_div_i,
  input  logic [1:0] abl_sel_i,
  output logic       up_o,
  output logic       dn_o
);
  import pfd_pkg::*;

  logic [NUM_CH-1:0] lvl_w;
  logic [NUM_CH-1:0] rise_w;
  logic [NUM_CH-1:0] out_w;
  logic              win_w;
  logic              clear_w;

  assign lvl_w[CH_REF] = ref_div_i;
  assign lvl_w[CH_FB]  = fb_div_i;

  pfd_edge_det #(.W(NUM_CH)) u_edge (
    .clk(clk), .rst(rst), .lvl_i(lvl_w), .rise_o(rise_w)
  );

  assign win_w = &out_w;

  pfd_clear_timer #(.D00(DLY_00), .D01(DLY_01), .D10(DLY_10), .D11(DLY_11)) u_timer (
    .clk(clk), .rst(rst), .win_i(win_w), .sel_i(abl_sel_i), .clear_o(clear_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pfd_chan u_chan (
      .clk(clk), .rst(rst), .rise_i(rise_w[g]), .win_i(win_w),
      .clear_i(clear_w), .out_q(out_w[g])
    );
  end

  assign up_o = out_w[CH_REF];
  assign dn_o = out_w[CH_FB];
endmodule

// File: rtl/phase_freq_det_chk.sv
module phase_freq_det_chk #(
  parameter int unsigned D00 = 3,
  parameter int unsigned D01 = 1,
  parameter int unsigned D10 = 6,
  parameter int unsigned D11 = 3
) (
  input logic clk,
  input logic rst,
  input logic ref_div_i,
  input logic fb_div_i,
  input logic up_o,
  input logic dn_o
);
  localparam int unsigned DMAX = pfd_pkg::max4(D00, D01, D10, D11);

  logic [7:0] ov_q;
  always_ff @(posedge clk) begin
    if (rst || !(up_o && dn_o)) ov_q <= '0;
    else if (ov_q != 8'hFF)     ov_q <= ov_q + 8'd1;
  end

  AST_RST_LOW: assert property (@(posedge clk) rst |=> (!up_o && !dn_o)); // R1
  AST_REF_SETS_UP: assert property (@(posedge clk) disable iff (rst)
    (ref_div_i && !$past(ref_div_i) && !$past(rst) && !(up_o && dn_o)) |=> up_o); // R2
  AST_FB_SETS_DN: assert property (@(posedge clk) disable iff (rst)
    (fb_div_i && !$past(fb_div_i) && !$past(rst) && !(up_o && dn_o)) |=> dn_o); // R2
  AST_CLEAR_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    (up_o && dn_o) |=> ((up_o && dn_o) || (!up_o && !dn_o))); // R3
  AST_OVERLAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    ov_q <= 8'(DMAX)); // R4
endmodule

bind phase_freq_det phase_freq_det_chk #(.D00(DLY_00), .D01(DLY_01), .D10(DLY_10), .D11(DLY_11)) u_chk (
  .clk(clk), .rst(rst), .ref_div_i(ref_div_i), .fb_div_i(fb_div_i), .up_o(up_o), .dn_o(dn_o)
);

// File: tb/phase_freq_det_bench.sv
`timescale 1ns/1ps
module phase_freq_det_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in = 1'b0;
  logic       fb_in = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       up, dn;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  phase_freq_det u_phase_freq_det (
    .clk(clk), .rst(rst), .ref_div_i(ref_in), .fb_div_i(fb_in),
    .abl_sel_i(sel), .up_o(up), .dn_o(dn)
  );

  // {code, lead (signed, >0 means reference first), up width, dn width}
  localparam logic [31:0] VEC [10] = '{
    {8'd0, 8'sd0,  8'd3, 8'd3},
    {8'd1, 8'sd0,  8'd1, 8'd1},
    {8'd2, 8'sd0,  8'd6, 8'd6},
    {8'd3, 8'sd0,  8'd3, 8'd3},
    {8'd0, 8'sd2,  8'd5, 8'd3},
    {8'd2, -8'sd3, 8'd6, 8'd9},
    {8'd1, 8'sd4,  8'd5, 8'd1},
    {8'd3, -8'sd1, 8'd3, 8'd4},
    {8'd2, 8'sd1,  8'd7, 8'd6},
    {8'd1, -8'sd2, 8'd1, 8'd3}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_pair(input logic [1:0] code, input int lead,
                          output int upw, output int dnw, output int uplast, output int dnlast);
    int rs, fs;
    rs = (lead < 0) ? -lead : 0;
    fs = (lead > 0) ? lead : 0;
    upw = 0; dnw = 0; uplast = -1; dnlast = -1;
    sel = code;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (up) begin upw++; uplast = i; end
      if (dn) begin dnw++; dnlast = i; end
      ref_in = (i >= rs);
      fb_in  = (i >= fs);
    end
    @(negedge clk);
    ref_in = 1'b0; fb_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    int upw, dnw, ul, dl;
    do_reset();
    chk("R1 up after reset", int'(up), 0);
    chk("R1 dn after reset", int'(dn), 0);

    // Table walk: R3, R4, R5, R6
    for (int v = 0; v < 10; v++) begin
      run_pair(VEC[v][31:24], int'($signed(VEC[v][23:16])), upw, dnw, ul, dl);
      chk($sformatf("R4/R5/R6 vec%0d up width", v), upw, int'(VEC[v][15:8]));
      chk($sformatf("R4/R5/R6 vec%0d dn width", v), dnw, int'(VEC[v][7:0]));
      chk($sformatf("R3 vec%0d common fall", v), ul, dl);
    end

    // R2: edge timing, level held high does not retrigger
    do_reset();
    sel = 2'b01;
    ref_in = 1'b1;
    #1 chk("R2 up before edge", int'(up), 0);
    @(negedge clk);
    chk("R2 up set", int'(up), 1);
    chk("R2 dn untouched", int'(dn), 0);
    repeat (3) @(negedge clk);
    chk("R2 up holds with level", int'(up), 1);
    fb_in = 1'b1;
    @(negedge clk);
    chk("R2 dn set", int'(dn), 1);
    @(negedge clk);
    chk("R2 cleared after D=1", int'(up) + int'(dn), 0);
    repeat (3) @(negedge clk);
    chk("R2 held levels give no new pulse", int'(up) + int'(dn), 0);

    // R7: edge during the clear window (D=6)
    do_reset();
    sel = 2'b10;
    ref_in = 1'b1; fb_in = 1'b1;             // t0, edges at P0
    @(negedge clk);                          // after P0
    chk("R7 both high", int'(up) + int'(dn), 2);
    ref_in = 1'b0;
    @(negedge clk);                          // after P1
    @(negedge clk);                          // after P2
    ref_in = 1'b1;                           // edge at P3, inside window
    repeat (3) @(negedge clk);               // after P5
    chk("R7 still in window", int'(up) + int'(dn), 2);
    @(negedge clk);                          // after P6
    chk("R7 up low after clear", int'(up), 0);
    chk("R7 dn low after clear", int'(dn), 0);
    @(negedge clk);                          // after P7
    chk("R7 pending up applied", int'(up), 1);
    chk("R7 dn stays low", int'(dn), 0);

    // R8: repeat edge on an already-high output (D=1)
    do_reset();
    sel = 2'b01;
    upw = 0; dnw = 0;
    ref_in = 1'b1;                           // edge at P0
    @(negedge clk); upw += int'(up); dnw += int'(dn); // after P0
    ref_in = 1'b0;
    @(negedge clk); upw += int'(up); dnw += int'(dn); // after P1
    ref_in = 1'b1;                           // ignored edge at P2
    @(negedge clk); upw += int'(up); dnw += int'(dn); // after P2
    fb_in = 1'b1;                            // edge at P3
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); upw += int'(up); dnw += int'(dn);
    end
    chk("R8 up width not extended", upw, 4);
    chk("R8 dn width", dnw, 1);
    chk("R8 nothing pending", int'(up) + int'(dn), 0);

    // R1: reset in mid-pulse
    sel = 2'b10;
    ref_in = 1'b0; fb_in = 1'b0;
    @(negedge clk);
    ref_in = 1'b1;
    @(negedge clk);
    chk("R1 pulse started", int'(up), 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-pulse reset up", int'(up), 0);
    chk("R1 mid-pulse reset dn", int'(dn), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 held level after reset gives no pulse", int'(up), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule